// File: doc/BRIEF.md
# Sparse Token-Chain Readout Controller

This block is the digital readout controller for a 64-channel detector front end. Every channel delivers a threshold-crossing flag and a peak-found flag. The peak amplitude and time values come in as ready-made 10-bit words. The controller latches which channels were hit in the current event. A hit also marks both adjacent channels for readout. At the chip edges this marking is carried to and from the neighbouring chips. The controller also publishes the address of the first channel that fired on a dedicated real-time output. When the readout token arrives, it emits one record per marked channel and then hands the token to the next chip in the chain.

A record holds the channel address, the captured amplitude, the captured time and a 6-bit coarse time stamp. The stamp comes from a free-running counter, sampled in the cycle the channel's peak-found flag rises. Each channel has a mask bit that removes it from the event completely. A marked channel whose peak never arrives is abandoned after a programmable number of waiting cycles. The event-clear input starts a new event.

The token walk is a four-state machine:
- IDLE waits for a rising edge on the token input, then moves to SCAN.
- SCAN selects the lowest pending marked channel. If that channel's peak is held, SCAN emits its record and stays in SCAN. If the peak is not yet held, SCAN moves to HOLD. If nothing is pending, SCAN moves to PASS.
- HOLD emits and returns to SCAN when the peak arrives. It also returns to SCAN, without a record, when the wait limit expires.
- PASS drives token-out for its single cycle and returns to IDLE.

Event-clear sends any state to IDLE.

Top module: `sro_readout_ctrl`

## Requirements
- R1: One cycle after the first cycle in which any unmasked channel crosses threshold, `rta_vld_o` rises. `rta_addr_o` then shows the lowest channel index among that cycle's crossings. Both hold unchanged through later hits until event-clear, which drops `rta_vld_o`.
- R2: A latched hit on channel i marks channels i-1, i and i+1 for readout. The channel address is the channel index, 0 to 63.
- R3: `nbr_lo_o` reports a latched hit on channel 0, and `nbr_hi_o` reports one on channel 63. A pulse on `nbr_lo_i` marks channel 0, and a pulse on `nbr_hi_i` marks channel 63. A neighbour input alone never sets the real-time address.
- R4: After a rising edge on `tok_i`, only marked channels are read out, in ascending address order. When their peaks are already held, the records come on consecutive cycles. The first record appears two cycles after the token edge is sampled.
- R5: After the last record, `tok_o` is high for exactly one cycle, in the cycle right after that record. With no marked channel, this pulse is the only output.
- R6: Each record carries its channel address and the amplitude and time words present when that channel's peak-found flag rose.
- R7: A masked channel is never latched as hit, never marked and never read out. Its hit does not mark its neighbours.
- R8: The token waits on a marked channel with no held peak. No record and no token-out appear until the peak arrives.
- R9: A marked channel that waits `tmo_lim_i` cycles without a peak is skipped with no record. The next record follows `tmo_lim_i`+2 cycles after the previous one.
- R10: The coarse stamp comes from a 6-bit counter that advances every cycle and wraps from 63 to 0. It is sampled in the cycle a channel's peak-found flag rises.
- R11: After reset, `rta_vld_o`, `rd_vld_o`, `tok_o`, `nbr_lo_o` and `nbr_hi_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_clr_i | input | 1 | Event clear: drops hits, peaks, marks and readout progress |
| thr_i | input | 64 | Per-channel threshold-crossing flags |
| pk_i | input | 64 | Per-channel peak-found flags |
| mask_i | input | 64 | Per-channel mask, 1 = channel excluded |
| amp_i | input | 640 | Amplitude words, channel c at bits [10c+9:10c] |
| tim_i | input | 640 | Time words, channel c at bits [10c+9:10c] |
| tmo_lim_i | input | 8 | Peak wait limit in cycles (1 or more) |
| nbr_lo_i | input | 1 | Neighbour hit from the lower chip, marks channel 0 |
| nbr_hi_i | input | 1 | Neighbour hit from the upper chip, marks channel 63 |
| nbr_lo_o | output | 1 | Channel 0 hit, to the lower chip |
| nbr_hi_o | output | 1 | Channel 63 hit, to the upper chip |
| rta_addr_o | output | 6 | Real-time first-hit address |
| rta_vld_o | output | 1 | Real-time address valid |
| tok_i | input | 1 | Token in, the rising edge starts readout |
| tok_o | output | 1 | Token out, one-cycle pulse |
| rd_vld_o | output | 1 | Record valid |
| rd_addr_o | output | 6 | Record channel address |
| rd_amp_o | output | 10 | Record amplitude |
| rd_tim_o | output | 10 | Record time |
| rd_ct_o | output | 6 | Record coarse stamp |

## Verification
The bench builds the block with its default parameters: 64 channels, 10-bit words, a 6-bit coarse counter and an 8-bit wait limit. At this size, hits on channels 0 and 63 reach the cross-chip neighbour pins. Peak rises 75 cycles apart carry the coarse counter through a wrap. The wait limit is driven at 4 to exercise the skip path. It is driven at 200 to show an indefinite wait for a late peak. The same-cycle double-hit pattern tests the lowest-index rule of the real-time address.

// File: rtl/sro_pkg.sv
package sro_pkg;
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_SCAN = 2'd1,
        TS_HOLD = 2'd2,
        TS_PASS = 2'd3
    } tok_state_e;
endpackage

// File: rtl/sro_hit_map.sv
module sro_hit_map #(
    parameter int NCH = 64,
    parameter int AW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_clr,
    input  logic [NCH-1:0] thr_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           nbr_lo_i,
    input  logic           nbr_hi_i,
    output logic [NCH-1:0] flag_o,
    output logic           nbr_lo_o,
    output logic           nbr_hi_o,
    output logic [AW-1:0]  rta_addr_o,
    output logic           rta_vld_o
);
    logic [NCH-1:0] hit_q;
    logic [NCH-1:0] new_hit;
    logic [NCH-1:0] lo_w;
    logic [NCH-1:0] hi_w;
    logic           nlo_q;
    logic           nhi_q;

    function automatic logic [AW-1:0] low_idx(input logic [NCH-1:0] v);
        logic [AW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = AW'(i);
        end
        return r;
    endfunction

    assign new_hit = thr_i & ~mask_i;

    // Sticky hit map and latched neighbour requests
    always_ff @(posedge clk) begin
        if (!rst_n || evt_clr) begin
            hit_q <= '0;
            nlo_q <= 1'b0;
            nhi_q <= 1'b0;
        end else begin
            hit_q <= hit_q | new_hit;
            nlo_q <= nlo_q | nbr_lo_i;
            nhi_q <= nhi_q | nbr_hi_i;
        end
    end

    // First-hit real-time address
    always_ff @(posedge clk) begin
        if (!rst_n || evt_clr) begin
            rta_addr_o <= '0;
            rta_vld_o  <= 1'b0;
        end else if (!rta_vld_o && (|new_hit)) begin
            rta_addr_o <= low_idx(new_hit);
            rta_vld_o  <= 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_nbr
        if (g == 0) begin : g_lo_edge
            assign lo_w[g] = nlo_q;
        end else begin : g_lo_mid
            assign lo_w[g] = hit_q[g-1];
        end
        if (g == NCH - 1) begin : g_hi_edge
            assign hi_w[g] = nhi_q;
        end else begin : g_hi_mid
            assign hi_w[g] = hit_q[g+1];
        end
        assign flag_o[g] = ~mask_i[g] & (hit_q[g] | lo_w[g] | hi_w[g]);
    end

    assign nbr_lo_o = hit_q[0];
    assign nbr_hi_o = hit_q[NCH-1];

    p_rta_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rta_vld_o && !evt_clr) |=> (rta_vld_o && $stable(rta_addr_o)));
    p_rta_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rta_vld_o && !evt_clr && (|(thr_i & ~mask_i))) |=> rta_vld_o);
    p_nbr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i[NCH-1] && !mask_i[NCH-1] && !evt_clr) |=> nbr_hi_o);
    p_nbr_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i[0] && !mask_i[0] && !evt_clr) |=> nbr_lo_o);
endmodule

// File: rtl/sro_peak_store.sv
module sro_peak_store #(
    parameter int NCH   = 64,
    parameter int AMP_W = 10,
    parameter int TIM_W = 10,
    parameter int CT_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_clr,
    input  logic [NCH-1:0]       pk_i,
    input  logic [NCH-1:0]       mask_i,
    input  logic [NCH*AMP_W-1:0] amp_i,
    input  logic [NCH*TIM_W-1:0] tim_i,
    output logic [NCH-1:0]       pk_q_o,
    output logic [NCH*AMP_W-1:0] amp_q_o,
    output logic [NCH*TIM_W-1:0] tim_q_o,
    output logic [NCH*CT_W-1:0]  ct_q_o
);
    localparam logic [CT_W-1:0] CT_MAX = '1;

    logic [CT_W-1:0]  ct_q;
    logic [NCH-1:0]   pk_prev_q;
    logic [NCH-1:0]   pk_held_q;
    logic [NCH-1:0]   pk_rise;
    logic [AMP_W-1:0] amp_r [NCH];
    logic [TIM_W-1:0] tim_r [NCH];
    logic [CT_W-1:0]  ct_r  [NCH];

    // Free-running coarse counter
    always_ff @(posedge clk) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_prev_q <= '0;
        else        pk_prev_q <= pk_i;
    end

    assign pk_rise = pk_i & ~pk_prev_q & ~mask_i & ~pk_held_q;

    always_ff @(posedge clk) begin
        if (!rst_n || evt_clr) pk_held_q <= '0;
        else                   pk_held_q <= pk_held_q | pk_rise;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                amp_r[g] <= '0;
                tim_r[g] <= '0;
                ct_r[g]  <= '0;
            end else if (pk_rise[g] && !evt_clr) begin
                amp_r[g] <= amp_i[g*AMP_W +: AMP_W];
                tim_r[g] <= tim_i[g*TIM_W +: TIM_W];
                ct_r[g]  <= ct_q;
            end
        end
        assign amp_q_o[g*AMP_W +: AMP_W] = amp_r[g];
        assign tim_q_o[g*TIM_W +: TIM_W] = tim_r[g];
        assign ct_q_o[g*CT_W +: CT_W]    = ct_r[g];
    end

    assign pk_q_o = pk_held_q;

    p_ct_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q != CT_MAX) |=> (ct_q == $past(ct_q) + 1'b1));
    p_ct_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q == CT_MAX) |=> (ct_q == '0));
endmodule

// File: rtl/sro_token_fsm.sv
module sro_token_fsm
    import sro_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int AW    = 6,
    parameter int AMP_W = 10,
    parameter int TIM_W = 10,
    parameter int CT_W  = 6,
    parameter int TMO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_clr,
    input  logic                 tok_i,
    input  logic [NCH-1:0]       flag_i,
    input  logic [NCH-1:0]       pk_q_i,
    input  logic [NCH*AMP_W-1:0] amp_q_i,
    input  logic [NCH*TIM_W-1:0] tim_q_i,
    input  logic [NCH*CT_W-1:0]  ct_q_i,
    input  logic [TMO_W-1:0]     tmo_lim_i,
    output logic                 tok_o,
    output logic                 rd_vld_o,
    output logic [AW-1:0]        rd_addr_o,
    output logic [AMP_W-1:0]     rd_amp_o,
    output logic [TIM_W-1:0]     rd_tim_o,
    output logic [CT_W-1:0]      rd_ct_o
);
    tok_state_e     state_q, state_n;
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] pend;
    logic [AW-1:0]  cur_q;
    logic [AW-1:0]  nxt;
    logic [AW-1:0]  sel;
    logic [TMO_W-1:0] cnt_q;
    logic           tok_d_q;
    logic           emit;
    logic           skip;
    logic           tmo_hit;

    function automatic logic [AW-1:0] low_idx(input logic [NCH-1:0] v);
        logic [AW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = AW'(i);
        end
        return r;
    endfunction

    assign pend    = flag_i & ~done_q;
    assign nxt     = low_idx(pend);
    assign tmo_hit = (cnt_q == tmo_lim_i - TMO_W'(1));

    // Next-state and selection
    always_comb begin
        state_n = state_q;
        emit    = 1'b0;
        skip    = 1'b0;
        sel     = nxt;
        unique case (state_q)
            TS_IDLE: begin
                if (tok_i && !tok_d_q) state_n = TS_SCAN;
            end
            TS_SCAN: begin
                if (!(|pend))         state_n = TS_PASS;
                else if (pk_q_i[nxt]) emit    = 1'b1;
                else                  state_n = TS_HOLD;
            end
            TS_HOLD: begin
                sel = cur_q;
                if (pk_q_i[cur_q]) begin
                    emit    = 1'b1;
                    state_n = TS_SCAN;
                end else if (tmo_hit) begin
                    skip    = 1'b1;
                    state_n = TS_SCAN;
                end
            end
            TS_PASS: state_n = TS_IDLE;
        endcase
        if (evt_clr) begin
            state_n = TS_IDLE;
            emit    = 1'b0;
            skip    = 1'b0;
        end
    end

    // State register and walk bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            done_q  <= '0;
            cur_q   <= '0;
            cnt_q   <= '0;
            tok_d_q <= 1'b0;
        end else begin
            state_q <= state_n;
            tok_d_q <= tok_i;
            if (evt_clr)           done_q      <= '0;
            else if (emit || skip) done_q[sel] <= 1'b1;
            if (state_q == TS_SCAN && state_n == TS_HOLD) begin
                cur_q <= nxt;
                cnt_q <= '0;
            end else if (state_q == TS_HOLD) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Record outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o  <= 1'b0;
            rd_addr_o <= '0;
            rd_amp_o  <= '0;
            rd_tim_o  <= '0;
            rd_ct_o   <= '0;
        end else begin
            rd_vld_o <= emit;
            if (emit) begin
                rd_addr_o <= sel;
                rd_amp_o  <= amp_q_i[sel*AMP_W +: AMP_W];
                rd_tim_o  <= tim_q_i[sel*TIM_W +: TIM_W];
                rd_ct_o   <= ct_q_i[sel*CT_W +: CT_W];
            end
        end
    end

    assign tok_o = (state_q == TS_PASS);

    p_tok_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tok_o |=> !tok_o);
    p_rd_in_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_o |-> ($past(state_q) == TS_SCAN || $past(state_q) == TS_HOLD));
    p_hold_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_HOLD && !pk_q_i[cur_q] && !tmo_hit && !evt_clr)
        |=> (state_q == TS_HOLD && !rd_vld_o && !tok_o));
    p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_HOLD && !pk_q_i[cur_q] && tmo_hit && !evt_clr)
        |=> (state_q == TS_SCAN && !rd_vld_o));
endmodule

// File: rtl/sro_readout_ctrl.sv
module sro_readout_ctrl #(
    parameter int NCH   = 64,
    parameter int AMP_W = 10,
    parameter int TIM_W = 10,
    parameter int CT_W  = 6,
    parameter int TMO_W = 8,
    localparam int AW   = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_clr_i,
    input  logic [NCH-1:0]       thr_i,
    input  logic [NCH-1:0]       pk_i,
    input  logic [NCH-1:0]       mask_i,
    input  logic [NCH*AMP_W-1:0] amp_i,
    input  logic [NCH*TIM_W-1:0] tim_i,
    input  logic [TMO_W-1:0]     tmo_lim_i,
    input  logic                 nbr_lo_i,
    input  logic                 nbr_hi_i,
    output logic                 nbr_lo_o,
    output logic                 nbr_hi_o,
    output logic [AW-1:0]        rta_addr_o,
    output logic                 rta_vld_o,
    input  logic                 tok_i,
    output logic                 tok_o,
    output logic                 rd_vld_o,
    output logic [AW-1:0]        rd_addr_o,
    output logic [AMP_W-1:0]     rd_amp_o,
    output logic [TIM_W-1:0]     rd_tim_o,
    output logic [CT_W-1:0]      rd_ct_o
);
    logic [NCH-1:0]       flag_w;
    logic [NCH-1:0]       pk_q_w;
    logic [NCH*AMP_W-1:0] amp_q_w;
    logic [NCH*TIM_W-1:0] tim_q_w;
    logic [NCH*CT_W-1:0]  ct_q_w;

    sro_hit_map #(.NCH(NCH), .AW(AW)) u_hit (
        .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr_i),
        .thr_i(thr_i), .mask_i(mask_i),
        .nbr_lo_i(nbr_lo_i), .nbr_hi_i(nbr_hi_i),
        .flag_o(flag_w), .nbr_lo_o(nbr_lo_o), .nbr_hi_o(nbr_hi_o),
        .rta_addr_o(rta_addr_o), .rta_vld_o(rta_vld_o)
    );

    sro_peak_store #(.NCH(NCH), .AMP_W(AMP_W), .TIM_W(TIM_W), .CT_W(CT_W)) u_pk (
        .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr_i),
        .pk_i(pk_i), .mask_i(mask_i), .amp_i(amp_i), .tim_i(tim_i),
        .pk_q_o(pk_q_w), .amp_q_o(amp_q_w), .tim_q_o(tim_q_w), .ct_q_o(ct_q_w)
    );

    sro_token_fsm #(.NCH(NCH), .AW(AW), .AMP_W(AMP_W), .TIM_W(TIM_W),
                    .CT_W(CT_W), .TMO_W(TMO_W)) u_tok (
        .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr_i), .tok_i(tok_i),
        .flag_i(flag_w), .pk_q_i(pk_q_w), .amp_q_i(amp_q_w),
        .tim_q_i(tim_q_w), .ct_q_i(ct_q_w), .tmo_lim_i(tmo_lim_i),
        .tok_o(tok_o), .rd_vld_o(rd_vld_o), .rd_addr_o(rd_addr_o),
        .rd_amp_o(rd_amp_o), .rd_tim_o(rd_tim_o), .rd_ct_o(rd_ct_o)
    );

    p_no_masked_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && $stable(mask_i) && !$past(evt_clr_i)) |-> !mask_i[rd_addr_o]);
endmodule

// File: tb/sro_readout_ctrl_bench.sv
module sro_readout_ctrl_bench;
    localparam int NCH = 64, AMP_W = 10, TIM_W = 10, CT_W = 6, TMO_W = 8, AW = 6;
    localparam int NT = 7;
    localparam logic [63:0] ONE = 64'd1;
    // stimulus table: hit pattern, mask, expected RTA (127 = none), expected records
    localparam logic [63:0] T_HIT [NT] = '{ONE << 10, (ONE << 20) | (ONE << 40), ONE,
                                           ONE << 63, ONE << 30, ONE << 30, (ONE << 5) | (ONE << 6)};
    localparam logic [63:0] T_MSK [NT] = '{64'd0, 64'd0, 64'd0, 64'd0, ONE << 31, ONE << 30, 64'd0};
    localparam int T_RTA [NT] = '{10, 20, 0, 63, 30, 127, 5};
    localparam int T_N   [NT] = '{3, 6, 2, 2, 2, 0, 4};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, evt_clr_i, nbr_lo_i, nbr_hi_i, tok_i;
    logic [NCH-1:0] thr_i, pk_i, mask_i;
    logic [NCH*AMP_W-1:0] amp_i;
    logic [NCH*TIM_W-1:0] tim_i;
    logic [TMO_W-1:0] tmo_lim_i;
    logic nbr_lo_o, nbr_hi_o, rta_vld_o, tok_o, rd_vld_o;
    logic [AW-1:0] rta_addr_o, rd_addr_o;
    logic [AMP_W-1:0] rd_amp_o;
    logic [TIM_W-1:0] rd_tim_o;
    logic [CT_W-1:0] rd_ct_o;

    sro_readout_ctrl u_sro_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_clr_i(evt_clr_i), .thr_i(thr_i), .pk_i(pk_i),
        .mask_i(mask_i), .amp_i(amp_i), .tim_i(tim_i), .tmo_lim_i(tmo_lim_i),
        .nbr_lo_i(nbr_lo_i), .nbr_hi_i(nbr_hi_i), .nbr_lo_o(nbr_lo_o), .nbr_hi_o(nbr_hi_o),
        .rta_addr_o(rta_addr_o), .rta_vld_o(rta_vld_o), .tok_i(tok_i), .tok_o(tok_o),
        .rd_vld_o(rd_vld_o), .rd_addr_o(rd_addr_o), .rd_amp_o(rd_amp_o),
        .rd_tim_o(rd_tim_o), .rd_ct_o(rd_ct_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int nrec = 0, ntok = 0, tok_cyc = 0;
    int rec_addr [64], rec_amp [64], rec_tim [64], rec_ct [64], rec_cyc [64];
    bit done_run = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rd_vld_o && nrec < 64) begin
            rec_addr[nrec] = rd_addr_o; rec_amp[nrec] = rd_amp_o;
            rec_tim[nrec] = rd_tim_o;   rec_ct[nrec] = rd_ct_o;
            rec_cyc[nrec] = cyc;        nrec++;
        end
        if (tok_o) begin ntok++; tok_cyc = cyc; end
    end

    function automatic int amp_of(int c); return (c * 37 + 5) % 1024; endfunction
    function automatic int tim_of(int c); return (c * 11 + 900) % 1024; endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_flags(logic [63:0] h, logic [63:0] m, bit nlo, bit nhi);
        logic [63:0] hh, f;
        hh = h & ~m;
        for (int i = 0; i < 64; i++)
            f[i] = ~m[i] & (hh[i] | (i > 0 ? hh[i-1] : nlo) | (i < 63 ? hh[i+1] : nhi));
        return f;
    endfunction

    task automatic new_event(input logic [63:0] m);
        thr_i = '0; pk_i = '0; nbr_lo_i = 0; nbr_hi_i = 0; tok_i = 0;
        mask_i = m; evt_clr_i = 1;
        @(negedge clk);
        evt_clr_i = 0; nrec = 0; ntok = 0;
    endtask

    task automatic fire(input logic [63:0] h);
        thr_i = h;
        @(negedge clk);
        thr_i = '0;
    endtask

    task automatic give_token();
        tok_i = 1;
        @(negedge clk);
        tok_i = 0;
    endtask

    task automatic check_records(input string req, input logic [63:0] fl, input bit consec);
        int k;
        chk(req, "record count", nrec, $countones(fl));
        k = 0;
        for (int i = 0; i < 64; i++) begin
            if (fl[i] && k < nrec) begin
                chk(req, "record address (ascending)", rec_addr[k], i);
                chk("R6", "record amplitude", rec_amp[k], amp_of(i));
                chk("R6", "record time", rec_tim[k], tim_of(i));
                if (consec && k > 0) chk("R4", "back-to-back records", rec_cyc[k] - rec_cyc[k-1], 1);
                k++;
            end
        end
        chk("R5", "token-out pulse count", ntok, 1);
        if (nrec > 0) chk("R5", "token-out after last record", tok_cyc - rec_cyc[nrec-1], 1);
    endtask

    initial begin
        rst_n = 0; evt_clr_i = 0; thr_i = '0; pk_i = '0; mask_i = '0;
        nbr_lo_i = 0; nbr_hi_i = 0; tok_i = 0; tmo_lim_i = 8'd8;
        for (int c = 0; c < NCH; c++) begin
            amp_i[c*AMP_W +: AMP_W] = AMP_W'(amp_of(c));
            tim_i[c*TIM_W +: TIM_W] = TIM_W'(tim_of(c));
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "rta_vld after reset", rta_vld_o, 0);
        chk("R11", "rd_vld after reset", rd_vld_o, 0);
        chk("R11", "tok_o after reset", tok_o, 0);
        chk("R11", "neighbour outputs after reset", {nbr_lo_o, nbr_hi_o}, 0);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int e = 0; e < NT; e++) begin
            logic [63:0] hh, fl;
            hh = T_HIT[e] & ~T_MSK[e];
            fl = exp_flags(T_HIT[e], T_MSK[e], 0, 0);
            new_event(T_MSK[e]);
            fire(T_HIT[e]);
            chk("R1", "rta valid", rta_vld_o, T_RTA[e] != 127);
            if (T_RTA[e] != 127) chk("R1", "rta lowest address", rta_addr_o, T_RTA[e]);
            chk("R3", "nbr_lo_o", nbr_lo_o, hh[0]);
            chk("R3", "nbr_hi_o", nbr_hi_o, hh[63]);
            pk_i = '1;
            @(negedge clk);
            give_token();
            repeat (80) @(negedge clk);
            chk("R2", "table pattern count", nrec, T_N[e]);
            check_records((T_MSK[e] != 0) ? "R7" : "R4", fl, 1);
        end

        // R1: later hit does not replace first address; clear drops it
        new_event('0);
        fire(ONE << 50);
        repeat (2) @(negedge clk);
        fire(ONE << 3);
        chk("R1", "rta holds first hit", rta_addr_o, 50);
        new_event('0);
        chk("R1", "rta cleared by event clear", rta_vld_o, 0);

        // R3: neighbour inputs
        new_event('0);
        nbr_lo_i = 1; @(negedge clk); nbr_lo_i = 0;
        chk("R3", "nbr_lo_i does not set rta", rta_vld_o, 0);
        pk_i = '1; @(negedge clk);
        give_token(); repeat (20) @(negedge clk);
        check_records("R3", ONE, 1);
        new_event('0);
        nbr_hi_i = 1; @(negedge clk); nbr_hi_i = 0;
        pk_i = '1; @(negedge clk);
        give_token(); repeat (20) @(negedge clk);
        check_records("R3", ONE << 63, 1);

        // R8: token waits for a late peak
        tmo_lim_i = 8'd200;
        new_event('0);
        fire(ONE << 40);
        give_token();
        repeat (20) @(negedge clk);
        chk("R8", "no record before peak", nrec, 0);
        chk("R8", "no token-out before peak", ntok, 0);
        pk_i = '1;
        repeat (20) @(negedge clk);
        check_records("R8", exp_flags(ONE << 40, 0, 0, 0), 1);

        // R9: stuck channel released by timeout
        tmo_lim_i = 8'd4;
        new_event('0);
        fire(ONE << 10);
        pk_i = (ONE << 9) | (ONE << 11);
        @(negedge clk);
        give_token();
        repeat (40) @(negedge clk);
        chk("R9", "records with one skipped", nrec, 2);
        if (nrec == 2) begin
            chk("R9", "first address", rec_addr[0], 9);
            chk("R9", "second address", rec_addr[1], 11);
            chk("R9", "gap across timeout", rec_cyc[1] - rec_cyc[0], 6);
        end
        chk("R9", "token still passed", ntok, 1);

        // R10: coarse stamps follow peak rise spacing, across a wrap
        tmo_lim_i = 8'd8;
        new_event('0);
        fire(ONE << 20);
        pk_i[19] = 1; repeat (5) @(negedge clk);
        pk_i[20] = 1; repeat (70) @(negedge clk);
        pk_i[21] = 1; @(negedge clk);
        give_token(); repeat (20) @(negedge clk);
        chk("R10", "coarse record count", nrec, 3);
        if (nrec == 3) begin
            chk("R10", "stamp spacing 5", int'(6'(rec_ct[1] - rec_ct[0])), 5);
            chk("R10", "stamp spacing 75 mod 64", int'(6'(rec_ct[2] - rec_ct[0])), 11);
        end

        done_run = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule